// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a binary-weighted capacitive successive-approximation converter. The capacitor array, the amplifier and the comparator are analog parts outside the block. The sequencer drives the switches around them and collects one result bit per step.

A one-cycle start request begins a conversion, which runs in four stages:
- **Track.** The amplifier feedback switch is closed, so the amplifier sits at unity gain, and every bottom plate follows the analog input.
- **Gap.** One cycle with every switch open.
- **Hold.** The feedback switch stays open and all bottom plates go to ground, which leaves the top plate floating with the sampled charge.
- **Binary search.** Starts at the most significant bit. In each step the capacitor under test is moved to the reference. After a settling time that is set per conversion, the comparator is sampled. A 1 keeps that capacitor at the reference and a 0 returns it to ground.

After the least significant step the full code is loaded into the result register and a one-cycle done pulse is given.

Capacitor `i` has a weight of 2^i unit capacitors, so the trial voltage of each step is half that of the step before. The bit pattern on the reference-select lines is therefore the trial code being tested.

Top module: `sar_seq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after the reset, all switch controls are low, `ref_sel` is 0, `done` is 0 and `result` is 0.
- R2: A `start` sampled high while idle puts the block in the track stage from the next cycle. The track stage lasts TRACK_CYC cycles, with `amp_fb_close` and `plate_to_input` high, and with `plate_gnd_en` low and `ref_sel` 0.
- R3: The track stage is followed by exactly one cycle in which `amp_fb_close`, `plate_to_input` and `plate_gnd_en` are all low. `plate_gnd_en` is never high in the same cycle as `amp_fb_close` or `plate_to_input`.
- R4: The hold stage follows the gap and lasts SAMPLE_CYC cycles, with `plate_gnd_en` high, `ref_sel` 0 and both track controls low.
- R5: The decision steps run from bit NBITS-1 down to bit 0. During step k, `ref_sel` bit k is 1, bits below k are 0, and `plate_gnd_en` is high. A nonzero `ref_sel` occurs only while `plate_gnd_en` is high.
- R6: Each decision step lasts `settle_cfg`+1 cycles, using the value of `settle_cfg` captured with `start`. `cmp_in` is sampled only at the clock edge that ends the step.
- R7: If the comparator gives 1 at the end of step k, bit k of `ref_sel` stays 1 for all later steps. If it gives 0, that bit is 0 from the next step on. With `cmp_in` = (input code >= `ref_sel`), the final code equals the input code.
- R8: `done` is high for exactly one cycle, TRACK_CYC+SAMPLE_CYC+2+NBITS*(`settle_cfg`+1) cycles after the edge that accepted `start`. In that cycle `result` holds the resolved code and all controls are back to idle.
- R9: `result` changes only at the edge that raises `done`, and otherwise keeps the previous conversion's code.
- R10: A `start` that arrives while a conversion is running has no effect on the stage timing or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, taken only when idle |
| settle_cfg | input | SETTLE_W | Extra settling cycles per decision step, captured at start |
| cmp_in | input | 1 | Comparator output, 1 when the input is at or above the trial level |
| amp_fb_close | output | 1 | Closes the amplifier unity-gain feedback switch |
| plate_to_input | output | 1 | Connects all bottom plates to the analog input |
| plate_gnd_en | output | 1 | Enables the per-capacitor ground/reference drivers |
| ref_sel | output | NBITS | Per-capacitor select: 1 for reference, 0 for ground |
| result | output | NBITS | Last completed conversion code |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong stage state shows in the same cycle on the three switch controls, because they are decoded directly from the stage register. A miscounted stage length shifts every later `ref_sel` pattern and moves the done pulse by the same number of cycles. A fault in the kept-bit register shows on `ref_sel` in the first step after the wrong decision, well before `result` is loaded. The comparator model in the bench returns the inverted answer until `ref_sel` has been stable for the configured settling time, so sampling one cycle early gives a wrong code.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes: one stage register drives all switch decoding.
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TRACK  = 3'd1,
        ST_GAP    = 3'd2,
        ST_HOLD   = 3'd3,
        ST_DECIDE = 3'd4
    } sar_stage_e;

endpackage

// File: rtl/sar_stage_ctrl.sv
// Stage sequencer: idle, track, gap, hold, then NBITS decision steps.
// Assumes: start is a single-cycle request and settle_cfg is valid with it.
// Provides the current stage, the bit under test and the end-of-step strobe.
module sar_stage_ctrl
    import sar_pkg::*;
#(
    parameter int NBITS      = 8,
    parameter int TRACK_CYC  = 4,
    parameter int SAMPLE_CYC = 2,
    parameter int SETTLE_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [SETTLE_W-1:0]      settle_cfg,
    output sar_stage_e               stage,
    output logic [$clog2(NBITS)-1:0] bit_idx,
    output logic                     step_end,
    output logic                     accept
);
    localparam int IDX_W = $clog2(NBITS);
    localparam int TW    = $clog2(TRACK_CYC + 1);
    localparam int SW    = $clog2(SAMPLE_CYC + 1);
    localparam int MW    = (TW > SW) ? TW : SW;
    localparam int CNT_W = (MW > SETTLE_W) ? MW : SETTLE_W;

    logic [CNT_W-1:0]    cnt;
    logic [SETTLE_W-1:0] settle_q;

    // Request accepted only from idle; later requests are dropped.
    assign accept   = (stage == ST_IDLE) && start;
    // Last cycle of a decision step: comparator is sampled at this edge.
    assign step_end = (stage == ST_DECIDE) &&
                      (cnt == CNT_W'(settle_q));

    // Stage register, in-stage cycle counter and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            settle_q <= '0;
        end else begin
            case (stage)
                ST_IDLE: begin
                    if (start) begin
                        stage    <= ST_TRACK;
                        cnt      <= '0;
                        settle_q <= settle_cfg;
                    end
                end
                ST_TRACK: begin
                    if (cnt == CNT_W'(TRACK_CYC - 1)) begin
                        stage <= ST_GAP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    stage <= ST_HOLD;
                    cnt   <= '0;
                end
                ST_HOLD: begin
                    if (cnt == CNT_W'(SAMPLE_CYC - 1)) begin
                        stage   <= ST_DECIDE;
                        cnt     <= '0;
                        bit_idx <= IDX_W'(NBITS - 1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DECIDE: begin
                    if (step_end) begin
                        cnt <= '0;
                        if (bit_idx == '0) stage <= ST_IDLE;
                        else               bit_idx <= bit_idx - 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: stage <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_switch_dec.sv
// Decodes the stage into the three shared switch controls.
// Assumes: stage is a register, so outputs are glitch-free per cycle and
// the gap stage separates feedback opening from plate grounding.
module sar_switch_dec
    import sar_pkg::*;
(
    input  sar_stage_e stage,
    output logic       amp_fb_close,
    output logic       plate_to_input,
    output logic       plate_gnd_en
);
    // Track closes feedback and ties plates to input; hold and decide ground them.
    always_comb begin
        amp_fb_close   = (stage == ST_TRACK);
        plate_to_input = (stage == ST_TRACK);
        plate_gnd_en   = (stage == ST_HOLD) || (stage == ST_DECIDE);
    end
endmodule

// File: rtl/sar_trial_reg.sv
// Holds the kept bits, forms the per-capacitor reference selects and loads
// the result with a one-cycle done pulse after the last step.
// Assumes: clear arrives once per conversion before the first step.
module sar_trial_reg #(
    parameter int NBITS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     in_decide,
    input  logic [$clog2(NBITS)-1:0] bit_idx,
    input  logic                     step_end,
    input  logic                     cmp_in,
    output logic [NBITS-1:0]         ref_sel,
    output logic [NBITS-1:0]         result,
    output logic                     done
);
    localparam int IDX_W = $clog2(NBITS);

    logic [NBITS-1:0] kept;
    logic [NBITS-1:0] kept_nx;
    logic [NBITS-1:0] trial;

    // Per-capacitor trial select and next kept value.
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        assign trial[i]   = in_decide && (bit_idx == IDX_W'(i));
        assign kept_nx[i] = (step_end && (bit_idx == IDX_W'(i))) ? cmp_in : kept[i];
    end

    // Reference selects: decided bits plus the one under test.
    assign ref_sel = in_decide ? (kept | trial) : '0;

    // Kept bits, result register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept   <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clear) begin
                kept <= '0;
            end else if (step_end) begin
                kept <= kept_nx;
                if (bit_idx == '0) begin
                    result <= kept_nx;
                    done   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sar_seq_top.sv
// Top of the successive-approximation sequencer: stage control, switch
// decode and trial register. Assumes an external binary-weighted array.
module sar_seq_top
    import sar_pkg::*;
#(
    parameter int NBITS      = 8,
    parameter int TRACK_CYC  = 4,
    parameter int SAMPLE_CYC = 2,
    parameter int SETTLE_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cfg,
    input  logic                cmp_in,
    output logic                amp_fb_close,
    output logic                plate_to_input,
    output logic                plate_gnd_en,
    output logic [NBITS-1:0]    ref_sel,
    output logic [NBITS-1:0]    result,
    output logic                done
);
    localparam int IDX_W = $clog2(NBITS);

    sar_stage_e       stage;
    logic [IDX_W-1:0] bit_idx;
    logic             step_end;
    logic             accept;

    sar_stage_ctrl #(
        .NBITS(NBITS), .TRACK_CYC(TRACK_CYC),
        .SAMPLE_CYC(SAMPLE_CYC), .SETTLE_W(SETTLE_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cfg(settle_cfg),
        .stage(stage), .bit_idx(bit_idx), .step_end(step_end), .accept(accept)
    );

    sar_switch_dec u_dec (
        .stage(stage), .amp_fb_close(amp_fb_close),
        .plate_to_input(plate_to_input), .plate_gnd_en(plate_gnd_en)
    );

    sar_trial_reg #(.NBITS(NBITS)) u_trial (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .in_decide(stage == ST_DECIDE), .bit_idx(bit_idx),
        .step_end(step_end), .cmp_in(cmp_in),
        .ref_sel(ref_sel), .result(result), .done(done)
    );
endmodule

// File: rtl/sar_seq_chk.sv
// Port-level temporal checks for sar_seq_top, attached by bind.
module sar_seq_chk #(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             amp_fb_close,
    input logic             plate_to_input,
    input logic             plate_gnd_en,
    input logic [NBITS-1:0] ref_sel,
    input logic [NBITS-1:0] result,
    input logic             done
);
    AST_FB_GND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(amp_fb_close && plate_gnd_en)); // R3
    AST_INPUT_GND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(plate_to_input && plate_gnd_en)); // R3
    AST_GAP_AFTER_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(amp_fb_close) |-> !plate_gnd_en); // R3
    AST_GND_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(plate_gnd_en) |-> !$past(amp_fb_close)); // R3
    AST_REF_NEEDS_GND: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_sel != '0) |-> plate_gnd_en); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R9
endmodule

bind sar_seq_top sar_seq_chk #(.NBITS(NBITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .amp_fb_close(amp_fb_close),
    .plate_to_input(plate_to_input), .plate_gnd_en(plate_gnd_en),
    .ref_sel(ref_sel), .result(result), .done(done)
);

// File: tb/tb_sar_seq_top.sv
`timescale 1ns/1ps
module tb_sar_seq_top;
    localparam int NB  = 8;
    localparam int TRK = 4;
    localparam int SMP = 2;
    localparam int SW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] settle_cfg = '0;
    logic          cmp_in = 1'b0;
    logic          amp_fb_close, plate_to_input, plate_gnd_en, done;
    logic [NB-1:0] ref_sel, result;

    int total = 0;
    int bad = 0;
    int stab = 0;
    logic [NB-1:0] prev_ref = '0;
    logic [NB-1:0] vin_r = '0;
    int            settle_r = 0;
    logic [NB-1:0] last_res = '0;

    always #10 clk = ~clk;

    sar_seq_top #(.NBITS(NB), .TRACK_CYC(TRK), .SAMPLE_CYC(SMP), .SETTLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cfg(settle_cfg),
        .cmp_in(cmp_in), .amp_fb_close(amp_fb_close), .plate_to_input(plate_to_input),
        .plate_gnd_en(plate_gnd_en), .ref_sel(ref_sel), .result(result), .done(done)
    );

    // Comparator model: correct only after ref_sel has settled long enough.
    always @(negedge clk) begin
        logic ok;
        if (ref_sel != prev_ref) stab = 0;
        else if (stab < 1000) stab = stab + 1;
        prev_ref = ref_sel;
        ok = (vin_r >= ref_sel);
        cmp_in <= (stab >= settle_r) ? ok : !ok;
    end

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // R1: reset state at the ports.
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!amp_fb_close && !plate_to_input && !plate_gnd_en && ref_sel == 0,
              "R1 controls in reset", {amp_fb_close, plate_to_input, plate_gnd_en}, 0);
        check(!done && result == 0, "R1 done/result in reset", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!amp_fb_close && !plate_gnd_en && ref_sel == 0 && !done,
              "R1 idle after reset", ref_sel, 0);
    endtask

    // One conversion with per-cycle checks of every stage (R2..R10).
    task automatic run_conv(input logic [NB-1:0] v, input int s, input bit poke);
        bit trk_ok = 1, gap_ok = 1, smp_ok = 1, dec_ok = 1, hold_ok = 1;
        int last;
        last = TRK + 1 + SMP + NB * (s + 1);
        @(negedge clk);
        vin_r = v; settle_r = s; settle_cfg = SW'(s); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= last + 2; c++) begin
            if (c > 1) @(negedge clk);
            if (poke) start = (c == TRK + 3) || (c == last - 1);
            if (c <= TRK) begin
                trk_ok &= amp_fb_close && plate_to_input && !plate_gnd_en && ref_sel == 0;
            end else if (c == TRK + 1) begin
                gap_ok &= !amp_fb_close && !plate_to_input && !plate_gnd_en;
            end else if (c <= TRK + 1 + SMP) begin
                smp_ok &= plate_gnd_en && !amp_fb_close && !plate_to_input && ref_sel == 0;
            end else if (c <= last) begin
                int k, mask, expv;
                k = NB - 1 - (c - TRK - 2 - SMP) / (s + 1);
                mask = ~((1 << (k + 1)) - 1) & ((1 << NB) - 1);
                expv = (int'(v) & mask) | (1 << k);
                if (!(plate_gnd_en && !amp_fb_close && int'(ref_sel) == expv)) begin
                    if (dec_ok)
                        $display("  step k=%0d ref=%0h exp=%0h", k, ref_sel, expv);
                    dec_ok = 0;
                end
            end
            if (c <= last) hold_ok &= (result == last_res) && !done;
            if (c == last + 1) begin
                check(done == 1'b1, poke ? "R10 done latency with extra start" : "R8 done latency",
                      done, 1);
                check(result == v, "R7 R8 result code", result, v);
                check(!plate_gnd_en && ref_sel == 0 && !amp_fb_close, "R8 idle at done", ref_sel, 0);
            end
            if (c == last + 2) check(done == 1'b0, "R8 done one cycle", done, 0);
        end
        start = 1'b0;
        check(trk_ok, "R2 track stage", trk_ok, 1);
        check(gap_ok, "R3 gap cycle", gap_ok, 1);
        check(smp_ok, "R4 hold stage", smp_ok, 1);
        check(dec_ok, poke ? "R5 R6 R7 R10 decision steps" : "R5 R6 R7 decision steps", dec_ok, 1);
        check(hold_ok, "R9 result held during conversion", hold_ok, 1);
        last_res = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        run_conv(8'h00, 0, 0);
        run_conv(8'hFF, 0, 0);
        run_conv(8'h80, 3, 0);
        run_conv(8'h7F, 3, 0);
        run_conv(8'h55, 1, 1);
        run_conv(8'hAA, 7, 0);
        run_conv(8'h01, 2, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule